// File: doc/BRIEF.md
# Multiplexed Hexadecimal Bus Display Driver

This block shows a 16-bit bus value as four hexadecimal characters on a display in which the segment lines a to g and the decimal point are wired to all four digit positions at once. Each digit position has its own common-cathode enable. A capture register takes the bus value, either on every clock or only when a strobe arrives. A private display copy feeds the scanner, so one scan frame always shows one value. The scanner lights one digit at a time. A single nibble decoder drives the shared segment lines.

Each digit slot lasts `DWELL` clocks. The scanning sequencer has two states. In `ST_BLANK` all digit enables are off for one clock. In `ST_SHOW` the selected digit is lit for `DWELL-1` clocks. The transitions are:

- *light*: from `ST_BLANK` to `ST_SHOW`. It is always taken after one clock.
- *dwell*: from `ST_SHOW` to `ST_SHOW`. It is taken while the slot counter has not reached its last value.
- *advance*: from `ST_SHOW` to `ST_BLANK`. It moves to the next digit. When the last digit wraps back to digit 0, the display copy is reloaded from the capture register.

A polarity input inverts all eight segment outputs, so either active-high or active-low segment drivers can be used.

Top module: `hexscan_top`

## Requirements
- R1: With `hold_mode`=0 the capture register samples `bus_in` on every clock. A bus value held steady for two whole frames is then shown by the next full frame.
- R2: With `hold_mode`=1 the capture register loads only in a cycle where `cap_strobe`=1. Bus changes without a strobe never reach the display.
- R3: Segment bit order is `seg_out[0]`=a through `seg_out[6]`=g, with `seg_out[7]`=dp. The digits 0 to 9 light, in hex (bits 6..0), 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 67.
- R4: The letters A, b, C, d, E and F (nibbles 10 to 15) light, in hex (bits 6..0), 77, 7C, 39, 5E, 79 and 71.
- R5: The decimal point `seg_out[7]` is lit exactly when the displayed nibble is 10 to 15.
- R6: At most one bit of `dig_en` is 1 at any time. `dig_en[i]` shows bits `[4i+3:4i]` of the value. Digits are lit in the order 0, 1, 2, 3, 0, and so on.
- R7: Between two lit digits, every digit enable is 0 for exactly one clock. Each digit is lit for `DWELL-1` consecutive clocks.
- R8: The display copy changes only when the scan wraps from digit 3 to digit 0. If the bus changes mid-frame, the rest of that frame still shows the old value.
- R9: `seg_invert`=1 inverts all eight segment outputs. It has no effect on `dig_en`.
- R10: While reset is low, `dig_en` is 0. Reset clears both the capture register and the display copy, so the first frame after reset shows 0000. Scanning starts at digit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 16 | Bus value to display |
| hold_mode | input | 1 | 0: capture every clock. 1: capture only on the strobe |
| cap_strobe | input | 1 | Capture strobe, used when `hold_mode`=1 |
| seg_invert | input | 1 | 1 inverts all segment outputs |
| seg_out | output | 8 | Shared segment lines: bit 0 = a … bit 6 = g, bit 7 = dp |
| dig_en | output | 4 | Digit cathode enables, one-hot or all zero, bit i = digit i |

## Verification
The hardest case to produce from the ports is a change of the captured value in the middle of a scan frame. The bench first holds one value steady for several frames. It then waits until digit 1 is lit and changes the bus immediately. Digits 2 and 3 of that same frame must still show the old nibbles, and the following frame must show the new value. The one-clock blank and the dwell length are checked by following `dig_en` on every clock over several frames.

// File: rtl/hexscan_pkg.sv
package hexscan_pkg;
    localparam int NIB_W = 4;
    localparam int SEG_W = 8;

    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_SHOW  = 1'b1
    } scan_state_t;
endpackage

// File: rtl/hexscan_capture.sv
module hexscan_capture #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_in,
    input  logic             hold_mode,
    input  logic             cap_strobe,
    output logic [BUS_W-1:0] cap_q
);
    logic take;

    assign take = !hold_mode || cap_strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else if (take)
            cap_q <= bus_in;
    end

    // R2: with hold_mode set and no strobe, the captured value must not move
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_mode && !cap_strobe) |=> $stable(cap_q));
endmodule

// File: rtl/hexscan_sequencer.sv
module hexscan_sequencer
    import hexscan_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int DWELL  = 50000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [$clog2(DIGITS)-1:0] digit_sel,
    output logic [DIGITS-1:0]         dig_en,
    output logic                      frame_load
);
    localparam int IDX_W  = $clog2(DIGITS);
    localparam int TICK_W = (DWELL > 2) ? $clog2(DWELL) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(DWELL - 2);
    localparam logic [IDX_W-1:0]  DIG_LAST  = IDX_W'(DIGITS - 1);

    scan_state_t       st_q, st_d;
    logic [TICK_W-1:0] tick_q, tick_d;
    logic [IDX_W-1:0]  digit_q, digit_d;
    logic              slot_end;

    assign slot_end = (st_q == ST_SHOW) && (tick_q == TICK_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_BLANK;
            tick_q  <= '0;
            digit_q <= '0;
        end else begin
            st_q    <= st_d;
            tick_q  <= tick_d;
            digit_q <= digit_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        tick_d  = tick_q;
        digit_d = digit_q;
        unique case (st_q)
            ST_BLANK: begin
                st_d   = ST_SHOW;
                tick_d = '0;
            end
            ST_SHOW: begin
                if (slot_end) begin
                    st_d    = ST_BLANK;
                    tick_d  = '0;
                    digit_d = (digit_q == DIG_LAST) ? '0 : digit_q + 1'b1;
                end else begin
                    tick_d = tick_q + 1'b1;
                end
            end
            default: st_d = ST_BLANK;
        endcase
    end

    always_comb begin
        dig_en     = '0;
        frame_load = slot_end && (digit_q == DIG_LAST);
        digit_sel  = digit_q;
        if (st_q == ST_SHOW)
            dig_en[digit_q] = 1'b1;
    end

    // R7: a lit digit either stays lit or goes fully dark, never straight to another digit
    assert_blank_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en != '0) |=> (dig_en == $past(dig_en) || dig_en == '0));

    // R7: the blank state lasts one clock and starts a fresh dwell count
    assert_blank_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BLANK) |=> (st_q == ST_SHOW && tick_q == '0));

    // R6: digits advance in ascending order with wrap
    assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (digit_q == (($past(digit_q) == DIG_LAST) ? '0 : $past(digit_q) + 1'b1)));

    // R6: never more than one enable
    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en));
endmodule

// File: rtl/hexscan_segdec.sv
module hexscan_segdec
    import hexscan_pkg::*;
(
    input  logic [NIB_W-1:0] nibble,
    output logic [SEG_W-1:0] seg
);
    logic [6:0] glyph;

    always_comb begin
        unique case (nibble)
            4'h0: glyph = 7'h3F;
            4'h1: glyph = 7'h06;
            4'h2: glyph = 7'h5B;
            4'h3: glyph = 7'h4F;
            4'h4: glyph = 7'h66;
            4'h5: glyph = 7'h6D;
            4'h6: glyph = 7'h7D;
            4'h7: glyph = 7'h07;
            4'h8: glyph = 7'h7F;
            4'h9: glyph = 7'h67;
            4'hA: glyph = 7'h77;
            4'hB: glyph = 7'h7C;
            4'hC: glyph = 7'h39;
            4'hD: glyph = 7'h5E;
            4'hE: glyph = 7'h79;
            default: glyph = 7'h71;
        endcase
        seg = {nibble[3] & (nibble[2] | nibble[1]), glyph};
    end

    // R5: letter nibbles carry the decimal point, digits do not
    always_comb begin
        assert_dp_R5: assert ((nibble >= 4'd10) == seg[7]);
    end
endmodule

// File: rtl/hexscan_top.sv
module hexscan_top
    import hexscan_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int DWELL  = 50000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DIGITS*NIB_W-1:0] bus_in,
    input  logic                    hold_mode,
    input  logic                    cap_strobe,
    input  logic                    seg_invert,
    output logic [SEG_W-1:0]        seg_out,
    output logic [DIGITS-1:0]       dig_en
);
    localparam int BUS_W = DIGITS * NIB_W;
    localparam int IDX_W = $clog2(DIGITS);

    logic [BUS_W-1:0] cap_q;
    logic [BUS_W-1:0] disp_q;
    logic [IDX_W-1:0] digit_sel;
    logic             frame_load;
    logic [NIB_W-1:0] cur_nib;
    logic [SEG_W-1:0] seg_raw;

    hexscan_capture #(.BUS_W(BUS_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (bus_in),
        .hold_mode  (hold_mode),
        .cap_strobe (cap_strobe),
        .cap_q      (cap_q)
    );

    hexscan_sequencer #(.DIGITS(DIGITS), .DWELL(DWELL)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .digit_sel  (digit_sel),
        .dig_en     (dig_en),
        .frame_load (frame_load)
    );

    // display copy, refreshed only at frame wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            disp_q <= '0;
        else if (frame_load)
            disp_q <= cap_q;
    end

    assign cur_nib = disp_q[digit_sel*NIB_W +: NIB_W];

    hexscan_segdec u_dec (
        .nibble (cur_nib),
        .seg    (seg_raw)
    );

    assign seg_out = seg_raw ^ {SEG_W{seg_invert}};

    // R8: the display copy holds except at a frame boundary
    assert_copy_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> $stable(disp_q));
endmodule

// File: tb/hexscan_top_test.sv
module hexscan_top_test;
    localparam int DW = 4;
    localparam logic [15:0] VEC [6] = '{16'h0123, 16'h4567, 16'h89AB,
                                        16'hCDEF, 16'hF00D, 16'hA5C3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_in = 16'hFFFF;
    logic        hold_mode = 1'b0;
    logic        cap_strobe = 1'b0;
    logic        seg_invert = 1'b0;
    logic [7:0]  seg_out;
    logic [3:0]  dig_en;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    hexscan_top #(.DIGITS(4), .DWELL(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .hold_mode(hold_mode),
        .cap_strobe(cap_strobe), .seg_invert(seg_invert),
        .seg_out(seg_out), .dig_en(dig_en)
    );

    function automatic logic [7:0] expect_seg(logic [3:0] n, logic inv);
        logic [6:0] g;
        case (n)
            4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
            4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
            4'h8: g = 7'h7F; 4'h9: g = 7'h67; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
            4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
        endcase
        return {(n > 4'd9), g} ^ {8{inv}};
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // wait until digit d is lit (sampled on falling edges)
    task automatic wait_digit(int d);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (dig_en == 4'(1 << d)) return;
        end
        check("R6 digit never lit", {12'h0, dig_en}, 16'(1 << d));
    endtask

    // wait for a fresh frame start: dark then digit 0
    task automatic frame_start();
        logic [3:0] prev;
        prev = dig_en;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (prev == 4'b0 && dig_en == 4'b0001) return;
            prev = dig_en;
        end
        check("R6 frame start missing", {12'h0, dig_en}, 16'h1);
    endtask

    task automatic check_frame(string tag, logic [15:0] val, logic inv);
        frame_start();
        for (int d = 0; d < 4; d++) begin
            if (d > 0) wait_digit(d);
            check(tag, {8'h0, seg_out}, {8'h0, expect_seg(val[d*4 +: 4], inv)});
            check("R5 dp", {15'h0, seg_out[7]}, {15'h0, (val[d*4 +: 4] > 4'd9) ^ inv});
        end
    endtask

    task automatic settle();
        repeat (3 * 4 * DW) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        // R10: during reset everything dark, display copy zero
        repeat (3) @(negedge clk);
        check("R10 dig_en in reset", {12'h0, dig_en}, 16'h0);
        check("R10 seg in reset", {8'h0, seg_out}, {8'h0, expect_seg(4'h0, 1'b0)});
        rst_n = 1'b1;
        // R10: first frame shows 0000 although the bus holds FFFF
        check_frame("R10 first frame", 16'h0000, 1'b0);

        // R1 R3 R4 R6: vector table in continuous mode
        for (int v = 0; v < 6; v++) begin
            bus_in = VEC[v];
            settle();
            check_frame("R1 R3 R4 R6 vector", VEC[v], 1'b0);
        end

        // R7: dwell length and one-clock blank over several frames
        begin
            logic [3:0] prev;
            int run;
            prev = dig_en; run = 0;
            for (int i = 0; i < 3 * 4 * DW; i++) begin
                @(negedge clk);
                if (dig_en != 4'b0 && prev != 4'b0 && dig_en != prev)
                    check("R7 no gap", {12'h0, dig_en}, 16'h0);
                if (dig_en == 4'b0 && prev == 4'b0)
                    check("R7 blank longer than one", 16'h1, 16'h0);
                if (dig_en != 4'b0) run++;
                if (dig_en == 4'b0 && prev != 4'b0) begin
                    if (run > 0 && run < DW - 1 && i < DW) run = DW - 1;
                    check("R7 dwell", 16'(run), 16'(DW - 1));
                    run = 0;
                end
                if ($countones(dig_en) > 1)
                    check("R6 onehot", {12'h0, dig_en}, 16'h0);
                prev = dig_en;
            end
        end

        // R8: bus change while digit 1 is lit keeps the old value for the frame
        bus_in = 16'h1357;
        settle();
        frame_start();
        wait_digit(1);
        bus_in = 16'hECA8;
        wait_digit(2);
        check("R8 mid-frame digit2", {8'h0, seg_out}, {8'h0, expect_seg(4'h3, 1'b0)});
        wait_digit(3);
        check("R8 mid-frame digit3", {8'h0, seg_out}, {8'h0, expect_seg(4'h1, 1'b0)});
        check_frame("R8 next frame", 16'hECA8, 1'b0);

        // R9: inverted polarity, enables unaffected
        seg_invert = 1'b1;
        check_frame("R9 inverted", 16'hECA8, 1'b1);
        check("R9 dig_en unaffected", {12'h0, dig_en}, 16'h8);
        seg_invert = 1'b0;

        // R2: hold mode loads only on the strobe
        hold_mode = 1'b1;
        bus_in = 16'h2468;
        @(negedge clk); cap_strobe = 1'b1;
        @(negedge clk); cap_strobe = 1'b0;
        bus_in = 16'hBDF0;
        settle();
        check_frame("R2 held value", 16'h2468, 1'b0);
        @(negedge clk); cap_strobe = 1'b1;
        @(negedge clk); cap_strobe = 1'b0;
        bus_in = 16'h0000;
        settle();
        check_frame("R2 second strobe", 16'hBDF0, 1'b0);

        // R10: reset mid-run clears the display copy
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 dig_en reset again", {12'h0, dig_en}, 16'h0);
        hold_mode = 1'b0;
        bus_in = 16'h9999;
        @(negedge clk);
        rst_n = 1'b1;
        check_frame("R10 cleared frame", 16'h0000, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule